// File: doc/BRIEF.md
# Shared-Clock Dual-Port Memory with Access Clash Detection

This block is a two-port word memory in which ports A and B run on one common clock and each can read or write any location in any cycle. Every cycle the block compares what the two ports are doing. When both touch the same word in the same cycle, it does not pretend that one of them won cleanly. It decides the outcome under a fixed rule and raises a flag so the requester can see what happened.

A word that is undefined is shown as all ones, the poison value. Suppose one port reads a word while the other writes it. The reader gets poison and a read-clash flag, and the write lands normally. Suppose both ports write one word. That word is stored as poison and both ports raise a write-clash flag. Two reads of one word are harmless. A saturating counter totals the clash cycles, and reset clears it. The stored contents survive reset, so software-visible state is kept across a soft reset of the access logic.

Top module: `dual_port_clash_ram`

## Requirements
- R1: A read (enable high, write low) presents the addressed word on that port's read data one clock later. The read data holds its value in cycles with no read on that port and is zero after reset.
- R2: A word written by one port is returned correctly by a read on the other port in any later cycle.
- R3: If one port reads and the other writes the same address in the same cycle, the reader's read data is all ones one clock later. In that same cycle its read-clash flag is high for exactly one clock, and the write is stored unchanged.
- R4: If both ports write the same address in the same cycle, that word is stored as all ones, and both write-clash flags are high for exactly one clock in the next cycle.
- R5: If both ports read the same address in the same cycle, no flag is raised and both return the stored word.
- R6: A clash is recognised only when both enables are high and both addresses are equal. A port with its enable low neither writes nor reads, and it causes no flag.
- R7: The clash counter rises by one after each cycle containing a read-write or write-write clash, and read-read is not counted. It stays at all ones once it gets there.
- R8: Synchronous active-low reset clears the flags, the read data and the counter on the next edge, and leaves the stored words untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| pa_en | input | 1 | Port A access enable |
| pa_wr | input | 1 | Port A write (1) or read (0) |
| pa_addr | input | ADDR_W | Port A word address |
| pa_wdata | input | DATA_W | Port A write data |
| pa_rdata | output | DATA_W | Port A registered read data |
| pa_rd_clash | output | 1 | Port A read hit a word port B was writing |
| pa_wr_clash | output | 1 | Port A write collided with a port B write |
| pb_en | input | 1 | Port B access enable |
| pb_wr | input | 1 | Port B write (1) or read (0) |
| pb_addr | input | ADDR_W | Port B word address |
| pb_wdata | input | DATA_W | Port B write data |
| pb_rdata | output | DATA_W | Port B registered read data |
| pb_rd_clash | output | 1 | Port B read hit a word port A was writing |
| pb_wr_clash | output | 1 | Port B write collided with a port A write |
| clash_count | output | CNT_W | Saturating total of clash cycles |

## Verification
The hardest state to reach from the ports is a counter that has saturated, because it takes 65535 clash cycles. The bench gets there by holding both ports on a write-write clash for a little more than that many cycles and then checking that the count stays pinned. The write-write case is also awkward, since its effect sits inside the memory. The bench makes it visible through a later ordinary read that must return poison. It also proves that a disabled write did nothing by reading the untouched word back.

// File: rtl/clash_ram_pkg.sv
package clash_ram_pkg;

    // Classification of what the two ports do to one word in one cycle
    typedef enum logic [1:0] {
        CLASH_NONE = 2'd0,
        CLASH_RR   = 2'd1,
        CLASH_RW   = 2'd2,
        CLASH_WW   = 2'd3
    } clash_kind_e;

    // True for the kinds that produce an undefined outcome
    function automatic logic is_harmful(input clash_kind_e k);
        return (k == CLASH_RW) || (k == CLASH_WW);
    endfunction

endpackage

// File: rtl/clash_detect.sv
// clash_detect
// Purely combinational. It compares the two port requests of the current
// cycle and says whether and how they collide.
// Assumes both requests belong to the same clock edge; it holds no state.
module clash_detect
    import clash_ram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              pa_en,
    input  logic              pa_wr,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic              pb_en,
    input  logic              pb_wr,
    input  logic [ADDR_W-1:0] pb_addr,
    output clash_kind_e       kind,
    output logic              pa_read_hit,
    output logic              pb_read_hit
);

    logic same_word;

    // Same word only when both ports are active and addresses agree
    always_comb begin
        same_word = pa_en && pb_en && (pa_addr == pb_addr);
    end

    // Sort the collision into one of the four kinds
    always_comb begin
        kind = CLASH_NONE;
        if (same_word) begin
            case ({pa_wr, pb_wr})
                2'b00:   kind = CLASH_RR;
                2'b11:   kind = CLASH_WW;
                default: kind = CLASH_RW;
            endcase
        end
    end

    // Name the reading side of a read-write collision
    always_comb begin
        pa_read_hit = (kind == CLASH_RW) && !pa_wr;
        pb_read_hit = (kind == CLASH_RW) && !pb_wr;
    end

endmodule

// File: rtl/word_store.sv
// word_store
// The storage array with two write paths and two registered read paths.
// It applies the collision outcome: a write-write collision stores poison,
// and a reader that collided with a write gets poison.
// Assumes the collision inputs come from clash_detect for the same cycle.
// Contents are not reset.
module word_store
    import clash_ram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pa_en,
    input  logic              pa_wr,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic [DATA_W-1:0] pa_wdata,
    input  logic              pb_en,
    input  logic              pb_wr,
    input  logic [ADDR_W-1:0] pb_addr,
    input  logic [DATA_W-1:0] pb_wdata,
    input  clash_kind_e       kind,
    input  logic              pa_read_hit,
    input  logic              pb_read_hit,
    output logic [DATA_W-1:0] pa_rdata,
    output logic [DATA_W-1:0] pb_rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] POISON = '1;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the writes of the cycle; a write-write collision stores poison
    always_ff @(posedge clk) begin
        if (kind == CLASH_WW) begin
            mem[pa_addr] <= POISON;
        end else begin
            if (pa_en && pa_wr) mem[pa_addr] <= pa_wdata;
            if (pb_en && pb_wr) mem[pb_addr] <= pb_wdata;
        end
    end

    // Port A read register, poisoned when port B wrote the same word
    always_ff @(posedge clk) begin
        if (!rst_n)                pa_rdata <= '0;
        else if (pa_en && !pa_wr)  pa_rdata <= pa_read_hit ? POISON : mem[pa_addr];
    end

    // Port B read register, poisoned when port A wrote the same word
    always_ff @(posedge clk) begin
        if (!rst_n)                pb_rdata <= '0;
        else if (pb_en && !pb_wr)  pb_rdata <= pb_read_hit ? POISON : mem[pb_addr];
    end

endmodule

// File: rtl/clash_counter.sv
// clash_counter
// Counts the cycles that held a harmful collision and sticks at its
// maximum value. It clears on synchronous reset.
// Assumes one increment at most per clock.
module clash_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP = '1;

    // Saturating increment
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (bump && count != TOP) count <= count + 1'b1;
    end

endmodule

// File: rtl/dual_port_clash_ram.sv
// dual_port_clash_ram
// A two-port memory on one clock. Same-word accesses get defined outcomes
// and per-port flags, and a counter keeps a total of them.
// Assumes both ports are synchronous to clk. Reads take one cycle, and the
// flags line up with the read data of the same access.
module dual_port_clash_ram
    import clash_ram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pa_en,
    input  logic              pa_wr,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic [DATA_W-1:0] pa_wdata,
    output logic [DATA_W-1:0] pa_rdata,
    output logic              pa_rd_clash,
    output logic              pa_wr_clash,
    input  logic              pb_en,
    input  logic              pb_wr,
    input  logic [ADDR_W-1:0] pb_addr,
    input  logic [DATA_W-1:0] pb_wdata,
    output logic [DATA_W-1:0] pb_rdata,
    output logic              pb_rd_clash,
    output logic              pb_wr_clash,
    output logic [CNT_W-1:0]  clash_count
);

    clash_kind_e kind;
    logic        pa_read_hit;
    logic        pb_read_hit;
    logic        both_wr_q;

    clash_detect #(.ADDR_W(ADDR_W)) u_detect (
        .pa_en       (pa_en),
        .pa_wr       (pa_wr),
        .pa_addr     (pa_addr),
        .pb_en       (pb_en),
        .pb_wr       (pb_wr),
        .pb_addr     (pb_addr),
        .kind        (kind),
        .pa_read_hit (pa_read_hit),
        .pb_read_hit (pb_read_hit)
    );

    word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .pa_en       (pa_en),
        .pa_wr       (pa_wr),
        .pa_addr     (pa_addr),
        .pa_wdata    (pa_wdata),
        .pb_en       (pb_en),
        .pb_wr       (pb_wr),
        .pb_addr     (pb_addr),
        .pb_wdata    (pb_wdata),
        .kind        (kind),
        .pa_read_hit (pa_read_hit),
        .pb_read_hit (pb_read_hit),
        .pa_rdata    (pa_rdata),
        .pb_rdata    (pb_rdata)
    );

    clash_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (is_harmful(kind)),
        .count (clash_count)
    );

    // Register the flags so they line up with the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_rd_clash <= 1'b0;
            pb_rd_clash <= 1'b0;
            both_wr_q   <= 1'b0;
        end else begin
            pa_rd_clash <= pa_read_hit;
            pb_rd_clash <= pb_read_hit;
            both_wr_q   <= (kind == CLASH_WW);
        end
    end

    // A write-write collision is reported on both sides
    always_comb begin
        pa_wr_clash = both_wr_q;
        pb_wr_clash = both_wr_q;
    end

endmodule

// File: rtl/dual_port_clash_ram_chk.sv
// dual_port_clash_ram_chk
// Temporal checks on the ports of dual_port_clash_ram, attached by bind.
module dual_port_clash_ram_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pa_en,
    input logic              pa_wr,
    input logic [ADDR_W-1:0] pa_addr,
    input logic [DATA_W-1:0] pa_rdata,
    input logic              pa_rd_clash,
    input logic              pa_wr_clash,
    input logic              pb_en,
    input logic              pb_wr,
    input logic [ADDR_W-1:0] pb_addr,
    input logic [DATA_W-1:0] pb_rdata,
    input logic              pb_rd_clash,
    input logic              pb_wr_clash,
    input logic [CNT_W-1:0]  clash_count
);

    // R3
    rd_poison_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_en && pb_en && !pa_wr && pb_wr && pa_addr == pb_addr)
        |=> (pa_rd_clash && pa_rdata == '1));

    // R3
    rd_poison_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_en && pb_en && pa_wr && !pb_wr && pa_addr == pb_addr)
        |=> (pb_rd_clash && pb_rdata == '1));

    // R4
    ww_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_en && pb_en && pa_wr && pb_wr && pa_addr == pb_addr)
        |=> (pa_wr_clash && pb_wr_clash));

    // R5
    rr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_en && pb_en && !pa_wr && !pb_wr && pa_addr == pb_addr)
        |=> (!pa_rd_clash && !pb_rd_clash && pa_rdata == pb_rdata));

    // R6
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pa_en || !pb_en)
        |=> (!pa_rd_clash && !pb_rd_clash && !pa_wr_clash && !pb_wr_clash));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clash_count == $past(clash_count)
                  || clash_count == $past(clash_count) + 1'b1));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (clash_count == '0 && !pa_rd_clash && !pb_rd_clash
                    && !pa_wr_clash && !pb_wr_clash));

endmodule

bind dual_port_clash_ram dual_port_clash_ram_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pa_en       (pa_en),
    .pa_wr       (pa_wr),
    .pa_addr     (pa_addr),
    .pa_rdata    (pa_rdata),
    .pa_rd_clash (pa_rd_clash),
    .pa_wr_clash (pa_wr_clash),
    .pb_en       (pb_en),
    .pb_wr       (pb_wr),
    .pb_addr     (pb_addr),
    .pb_rdata    (pb_rdata),
    .pb_rd_clash (pb_rd_clash),
    .pb_wr_clash (pb_wr_clash),
    .clash_count (clash_count)
);

// File: tb/test_dual_port_clash_ram.sv
module test_dual_port_clash_ram;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int VW = 2 * (2 + AW + DW) + 2 * DW + 4;
    localparam int NV = 12;

    // row: A{en,wr,addr,wdata} B{en,wr,addr,wdata} expA expB flags{ard,awc,brd,bwc}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1,1'b1,4'd3,16'h1111, 1'b1,1'b1,4'd5,16'h2222, 16'h0000,16'h0000, 4'b0000}, // R1
        {1'b1,1'b0,4'd5,16'h0000, 1'b1,1'b0,4'd3,16'h0000, 16'h2222,16'h1111, 4'b0000}, // R2
        {1'b1,1'b0,4'd3,16'h0000, 1'b1,1'b0,4'd3,16'h0000, 16'h1111,16'h1111, 4'b0000}, // R5
        {1'b1,1'b1,4'd3,16'h3333, 1'b1,1'b0,4'd3,16'h0000, 16'h1111,16'hFFFF, 4'b0010}, // R3
        {1'b1,1'b0,4'd3,16'h0000, 1'b0,1'b0,4'd0,16'h0000, 16'h3333,16'hFFFF, 4'b0000}, // R3
        {1'b1,1'b1,4'd7,16'hAAAA, 1'b1,1'b1,4'd7,16'hBBBB, 16'h3333,16'hFFFF, 4'b0101}, // R4
        {1'b1,1'b0,4'd7,16'h0000, 1'b1,1'b0,4'd5,16'h0000, 16'hFFFF,16'h2222, 4'b0000}, // R4
        {1'b1,1'b0,4'd5,16'h0000, 1'b0,1'b1,4'd5,16'h5555, 16'h2222,16'h2222, 4'b0000}, // R6
        {1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b0,4'd5,16'h0000, 16'h2222,16'h2222, 4'b0000}, // R6
        {1'b1,1'b0,4'd3,16'h0000, 1'b1,1'b1,4'd3,16'h4444, 16'hFFFF,16'h2222, 4'b1000}, // R3
        {1'b1,1'b1,4'd1,16'h0101, 1'b1,1'b1,4'd2,16'h0202, 16'hFFFF,16'h2222, 4'b0000}, // R6
        {1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b0,4'd3,16'h0000, 16'hFFFF,16'h4444, 4'b0000}  // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pa_en = 1'b0, pa_wr = 1'b0, pb_en = 1'b0, pb_wr = 1'b0;
    logic [AW-1:0] pa_addr = '0, pb_addr = '0;
    logic [DW-1:0] pa_wdata = '0, pb_wdata = '0;
    logic [DW-1:0] pa_rdata, pb_rdata;
    logic          pa_rd_clash, pa_wr_clash, pb_rd_clash, pb_wr_clash;
    logic [CW-1:0] clash_count;

    int n_run = 0;
    int n_fail = 0;
    string row_req [NV];

    always #4 clk = ~clk;

    dual_port_clash_ram #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dual_port_clash_ram (
        .clk(clk), .rst_n(rst_n),
        .pa_en(pa_en), .pa_wr(pa_wr), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
        .pa_rdata(pa_rdata), .pa_rd_clash(pa_rd_clash), .pa_wr_clash(pa_wr_clash),
        .pb_en(pb_en), .pb_wr(pb_wr), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_rdata(pb_rdata), .pb_rd_clash(pb_rd_clash), .pb_wr_clash(pb_wr_clash),
        .clash_count(clash_count)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample just after the rising edge
    task automatic step(input logic ae, aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                        input logic be, bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
        @(negedge clk);
        pa_en = ae; pa_wr = aw; pa_addr = aa; pa_wdata = ad;
        pb_en = be; pb_wr = bw; pb_addr = ba; pb_wdata = bd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        row_req = '{"R1","R2","R5","R3","R3","R4","R4","R6","R6","R3","R6","R3"};

        // R8: reset state
        step(0,0,0,0, 0,0,0,0);
        step(0,0,0,0, 0,0,0,0);
        check("R8", "reset rdata A", 32'(pa_rdata), 0);
        check("R8", "reset rdata B", 32'(pb_rdata), 0);
        check("R8", "reset flags", 32'({pa_rd_clash,pa_wr_clash,pb_rd_clash,pb_wr_clash}), 0);
        check("R8", "reset count", 32'(clash_count), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            step(v[79], v[78], v[77:74], v[73:58], v[57], v[56], v[55:52], v[51:36]);
            check(row_req[i], $sformatf("row %0d rdata A", i), 32'(pa_rdata), 32'(v[35:20]));
            check(row_req[i], $sformatf("row %0d rdata B", i), 32'(pb_rdata), 32'(v[19:4]));
            check(row_req[i], $sformatf("row %0d flags", i),
                  32'({pa_rd_clash,pa_wr_clash,pb_rd_clash,pb_wr_clash}), 32'(v[3:0]));
        end

        // R7: three harmful clashes in the table, read-read not counted
        check("R7", "count after table", 32'(clash_count), 3);

        // R1: read data holds while idle
        step(0,0,0,0, 0,0,0,0);
        check("R1", "hold A", 32'(pa_rdata), 32'h0000FFFF);

        // R8: reset clears counter but keeps memory
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R8", "count cleared", 32'(clash_count), 0);
        check("R8", "rdata cleared", 32'(pb_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1,0,4'd1,0, 1,0,4'd2,0);
        check("R8", "memory kept A", 32'(pa_rdata), 32'h0101);
        check("R8", "memory kept B", 32'(pb_rdata), 32'h0202);

        // R4: flag lasts one cycle only
        step(1,1,4'd9,16'h1234, 1,1,4'd9,16'h4321);
        check("R4", "ww flag set", 32'({pa_wr_clash,pb_wr_clash}), 3);
        step(0,0,0,0, 0,0,0,0);
        check("R4", "ww flag single cycle", 32'({pa_wr_clash,pb_wr_clash}), 0);
        check("R7", "count after ww", 32'(clash_count), 1);

        // R7: saturation
        @(negedge clk);
        pa_en = 1; pa_wr = 1; pa_addr = 0; pb_en = 1; pb_wr = 1; pb_addr = 0;
        for (int k = 0; k < 65540; k++) @(posedge clk);
        #1;
        check("R7", "count saturated", 32'(clash_count), 32'hFFFF);
        step(0,0,0,0, 0,0,0,0);
        check("R7", "count stays saturated", 32'(clash_count), 32'hFFFF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule